// File: doc/BRIEF.md
# Host Bus Ownership Handshake

This block decides who drives a shared local memory bus: the core, or an external host. The host asks for the bus by pulling an active-low request line. The request is asynchronous, so it first passes through a two-stage synchroniser into the core clock. The block then waits until any internal bus cycle in progress has finished. Once that cycle is done, it turns off the local bus drivers. One clock later it answers with an active-low acknowledge.

When the host lets the request go, the acknowledge returns high on the first edge that sees the inactive synchronised level. The bus drivers are switched back on one clock after that, so the two parties never drive the bus at the same time.

Alongside the handshake, the block publishes a registered two-bit code for the most urgent pending internal memory request. Outside logic can read this code to judge whether to give the bus back.

Top module: `hbo_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `bus_oe`=0, `host_ack_n`=1 and `pend_code`=00. The first edge with `rst` low and no request sets `bus_oe`=1.
- R2: `host_req_n` is used only after two synchronising flip-flops. If `host_req_n` is low at edge k, and the block owns an idle bus, `bus_oe` falls after edge k+2 and not earlier.
- R3: While `cyc_busy` is high, the block keeps `bus_oe`=1 even when a synchronised request is present. It releases at the first edge where `cyc_busy` is low.
- R4: `host_ack_n` goes low exactly one edge after `bus_oe` has gone low. `host_ack_n` is never low while `bus_oe` is 1.
- R5: The first edge that sees the synchronised request inactive sets `host_ack_n`=1 while `bus_oe` stays 0. The next edge sets `bus_oe`=1.
- R6: The request may be withdrawn after the bus has been released but before the acknowledge. In that case the block takes the bus back on the next edge (`bus_oe`=1) without pulsing `host_ack_n` low.
- R7: `pend_code` is registered one edge after `mem_req` and is coded as follows:
  - 11 when bit 3 is set.
  - 10 when bit 2 is the highest set bit.
  - 01 when bit 1 or bit 0 is the highest set bit.
  - 00 when no bit is set.
- R8: While the host holds the bus, `cyc_busy` has no effect: `bus_oe` stays 0 and `host_ack_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_n | input | 1 | Asynchronous active-low bus request from the host |
| cyc_busy | input | 1 | High while an internal bus cycle is in flight |
| mem_req | input | 4 | Pending internal memory requests, bit 3 most urgent |
| bus_oe | output | 1 | Local bus drive enable (0 = high impedance) |
| host_ack_n | output | 1 | Active-low acknowledge to the host |
| pend_code | output | 2 | Priority code of the most urgent pending request |

## Verification
The handshake is driven with several request patterns, each exposing a different timing rule:
- A clean long request on an idle bus measures the synchroniser latency.
- The same request overlapped by a multi-cycle busy cycle shows whether release really waits.
- A one-cycle request pulse reaches the released state and is then withdrawn, which separates the abort path from the full handshake.
- Busy toggling during host ownership shows whether the held state ignores it.

The request vector is swept through all sixteen values, so every priority boundary of the code is compared against the model.

// File: rtl/hbo_pkg.sv
package hbo_pkg;
  typedef enum logic [1:0] {
    HB_OWN    = 2'd0,
    HB_DROP   = 2'd1,
    HB_HOST   = 2'd2,
    HB_RETURN = 2'd3
  } hb_state_t;
endpackage

// File: rtl/hbo_sync.sv
module hbo_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbo_fsm.sv
module hbo_fsm
  import hbo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_act,
  input  logic cyc_busy,
  output logic bus_oe,
  output logic host_ack_n
);
  hb_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      HB_OWN:    if (req_act && !cyc_busy) state_nx = HB_DROP;
      HB_DROP:   state_nx = req_act ? HB_HOST : HB_OWN;
      HB_HOST:   if (!req_act) state_nx = HB_RETURN;
      HB_RETURN: state_nx = HB_OWN;
      default:   state_nx = HB_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= HB_OWN;
      bus_oe     <= 1'b0;
      host_ack_n <= 1'b1;
    end else begin
      state      <= state_nx;
      bus_oe     <= (state_nx == HB_OWN);
      host_ack_n <= (state_nx != HB_HOST);
    end
  end
endmodule

// File: rtl/hbo_prio.sv
module hbo_prio #(
  parameter int NREQ   = 4,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREQ-1:0]   req,
  output logic [CODE_W-1:0] code
);
  localparam int MAXC = (1 << CODE_W) - 1;
  localparam int DEN  = (NREQ > 1) ? (NREQ - 1) : 1;

  logic [CODE_W-1:0] code_nx;

  always_comb begin
    code_nx = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req[i]) code_nx = CODE_W'(1 + (i * (MAXC - 1)) / DEN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code <= '0;
    else     code <= code_nx;
  end
endmodule

// File: rtl/hbo_ctrl.sv
module hbo_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int NREQ        = 4,
  parameter int CODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req_n,
  input  logic              cyc_busy,
  input  logic [NREQ-1:0]   mem_req,
  output logic              bus_oe,
  output logic              host_ack_n,
  output logic [CODE_W-1:0] pend_code
);
  logic req_n_s;

  hbo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (host_req_n),
    .q   (req_n_s)
  );

  hbo_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_act    (~req_n_s),
    .cyc_busy   (cyc_busy),
    .bus_oe     (bus_oe),
    .host_ack_n (host_ack_n)
  );

  hbo_prio #(.NREQ(NREQ), .CODE_W(CODE_W)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .req  (mem_req),
    .code (pend_code)
  );
endmodule

// File: rtl/hbo_ctrl_chk.sv
module hbo_ctrl_chk #(
  parameter int NREQ   = 4,
  parameter int CODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_req_n,
  input logic              cyc_busy,
  input logic [NREQ-1:0]   mem_req,
  input logic              bus_oe,
  input logic              host_ack_n,
  input logic [CODE_W-1:0] pend_code
);
  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!bus_oe && host_ack_n && pend_code == '0)); // R1
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst) $fell(bus_oe) |-> $past(!host_req_n, 3)); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (bus_oe && cyc_busy) |=> bus_oe); // R3
  AST_ACK_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst) !host_ack_n |-> !bus_oe); // R4
  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) $fell(host_ack_n) |-> $past(!bus_oe)); // R4
  AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) $rose(bus_oe) |-> $past(host_ack_n)); // R5
  AST_TOP_CODE: assert property (@(posedge clk) disable iff (rst) mem_req[NREQ-1] |=> (pend_code == '1)); // R7
  AST_NONE_CODE: assert property (@(posedge clk) disable iff (rst) (mem_req == '0) |=> (pend_code == '0)); // R7
endmodule

bind hbo_ctrl hbo_ctrl_chk #(.NREQ(NREQ), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_req_n (host_req_n),
  .cyc_busy   (cyc_busy),
  .mem_req    (mem_req),
  .bus_oe     (bus_oe),
  .host_ack_n (host_ack_n),
  .pend_code  (pend_code)
);

// File: tb/hbo_ctrl_bench.sv
module hbo_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_req_n = 1'b1;
  logic       cyc_busy = 1'b0;
  logic [3:0] mem_req = 4'd0;
  logic       bus_oe;
  logic       host_ack_n;
  logic [1:0] pend_code;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  hbo_ctrl u_hbo_ctrl (
    .clk(clk), .rst(rst), .host_req_n(host_req_n), .cyc_busy(cyc_busy),
    .mem_req(mem_req), .bus_oe(bus_oe), .host_ack_n(host_ack_n), .pend_code(pend_code)
  );

  // Behavioural reference model: 0 own, 1 released, 2 host, 3 returning
  int m_req_q[$];
  int m_st = 0, m_oe = 0, m_ack = 1, m_code = 0;

  always @(posedge clk) begin
    int rq, nst;
    cycles++;
    if (rst) begin
      m_req_q = '{1, 1};
      m_st = 0; m_oe = 0; m_ack = 1; m_code = 0;
    end else begin
      rq = (m_req_q[0] == 0);
      nst = m_st;
      case (m_st)
        0: nst = (rq && !cyc_busy) ? 1 : 0;
        1: nst = rq ? 2 : 0;
        2: nst = rq ? 2 : 3;
        default: nst = 0;
      endcase
      m_st = nst;
      m_oe = (nst == 0);
      m_ack = (nst != 2);
      void'(m_req_q.pop_front());
      m_req_q.push_back(int'(host_req_n));
      if (mem_req[3]) m_code = 3;
      else if (mem_req[2]) m_code = 2;
      else if (mem_req[1] || mem_req[0]) m_code = 1;
      else m_code = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  // Per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (cycles > 0) begin
      chk(rst ? "R1 bus_oe" : "R2/R3/R6/R8 bus_oe", int'(bus_oe), m_oe);
      chk(rst ? "R1 host_ack_n" : "R4/R5 host_ack_n", int'(host_ack_n), m_ack);
      chk(rst ? "R1 pend_code" : "R7 pend_code", int'(pend_code), m_code);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    #1 rst = 1'b0;
    wait_cyc(4);
    // R2: plain request on an idle bus
    #1 host_req_n = 1'b0;
    wait_cyc(8);
    // R8: busy toggles while host owns
    for (int i = 0; i < 6; i++) begin
      #1 cyc_busy = ~cyc_busy;
      wait_cyc(1);
    end
    #1 cyc_busy = 1'b0;
    // R5: withdraw
    host_req_n = 1'b1;
    wait_cyc(6);
    // R3: request while busy for several cycles
    #1 cyc_busy = 1'b1; host_req_n = 1'b0;
    wait_cyc(7);
    #1 cyc_busy = 1'b0;
    wait_cyc(6);
    #1 host_req_n = 1'b1;
    wait_cyc(6);
    // R6: one-cycle pulse aborts after release
    #1 host_req_n = 1'b0;
    wait_cyc(1);
    #1 host_req_n = 1'b1;
    wait_cyc(8);
    // R7: sweep of all request patterns
    for (int v = 0; v < 16; v++) begin
      #1 mem_req = 4'(v);
      wait_cyc(2);
    end
    #1 mem_req = 4'd0;
    // R1: reset in the middle of host ownership
    host_req_n = 1'b0;
    wait_cyc(6);
    #1 rst = 1'b1;
    wait_cyc(3);
    #1 rst = 1'b0; host_req_n = 1'b1;
    wait_cyc(6);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule